// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single output line. An 8-bit line control value, written through its own strobe, sets the frame format at run time: the data length (5 to 8 bits), the stop time, the parity mode and a break override. A word is written into a one-entry holding register with a load strobe. When the shifter is idle it takes the word, copies the current format and sends a start bit, the data bits LSB first, an optional parity bit and the stop time.

Bit timing is set by an external tick input, with sixteen ticks per bit. An empty flag and a busy flag let the surrounding logic pace its writes. Break holds the line low at once. When break is cleared during a frame, the line returns to normal only at the next bit edge. A word written while break is set is still shifted out internally, so the empty flag keeps advancing.

Top module: `async_tx`

## Requirements
- R1: After reset txd_o is 1, thr_empty_o is 1, tx_busy_o is 0 and lcr_rdata_o is 0x00.
- R2: Control bits [1:0] select the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. A frame is a start bit at 0 followed by the data bits LSB first. Each bit lasts 16 ticks.
- R3: With control bit 2 at 0 the stop time is one bit (16 ticks at 1). With bit 2 at 1 it is 24 ticks for a 5-bit word and 32 ticks for a 6-, 7- or 8-bit word.
- R4: With control bit 3 at 0 no parity bit is sent, and the stop time follows the last data bit directly.
- R5: With bit 3 at 1 and bit 5 at 0, a 16-tick parity bit follows the data. It makes the number of ones in the data plus parity odd when bit 4 is 0, and even when bit 4 is 1.
- R6: With bits 3 and 5 both at 1, the parity bit is the constant 1 when bit 4 is 0, and the constant 0 when bit 4 is 1.
- R7: While the stored control bit 6 is 1, txd_o is 0. After it is cleared, txd_o returns to frame or idle level at the next bit edge while a frame runs, or one cycle later when idle. The frame keeps running throughout.
- R8: A frame starts in the cycle after the holding register is full while the shifter is idle. The holding register becomes empty at that same edge. A word loaded during a frame waits for the end of that frame. The line idles at 1.
- R9: When a load coincides with the shifter taking the held word, the new word is kept and thr_empty_o stays 0. The new word is sent as the next frame.
- R10: lcr_rdata_o returns the last written control byte, bit 7 included. Bit 7 has no effect on framing.
- R11: The format is captured at frame start. Control writes during a frame do not change that frame, except for break.
- R12: Frame timing advances only on ticks. Without ticks the line holds its current bit, and ticks while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lcr_we_i | input | 1 | Control byte write strobe |
| lcr_wdata_i | input | 8 | Control byte |
| lcr_rdata_o | output | 8 | Stored control byte |
| thr_load_i | input | 1 | Holding register load strobe |
| thr_data_i | input | 8 | Data word (low bits used per length) |
| tick_i | input | 1 | Baud tick, 16 per bit |
| thr_empty_o | output | 1 | Holding register empty |
| tx_busy_o | output | 1 | Shifter sending a frame |
| txd_o | output | 1 | Serial output line |

## Verification
Two functions can fall in the same cycle. One is the shifter taking the held word; the other is a fresh load into the holding register. The bench provokes the overlap with two load strobes on consecutive cycles from idle, so that the second strobe lands on the taking edge. It is judged by the empty flag staying low and by the second word appearing as the next frame. A second overlap comes from clearing break in the middle of a bit. The model keeps the line low until that bit's edge and compares the output on every clock.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PARITY, PH_STOP
  } phase_e;

  typedef struct packed {
    logic       bank;
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       stop2;
    logic [1:0] len;
  } lcr_t;

  // xor over the active data bits only
  function automatic logic data_xor(logic [7:0] d, logic [1:0] len);
    logic r;
    r = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < 5 + int'(len)) r = r ^ d[i];
    end
    return r;
  endfunction

  function automatic logic parity_bit(logic [7:0] d, logic [1:0] len,
                                      logic even, logic stick);
    logic x;
    x = data_xor(d, len);
    if (stick) return ~even;
    return even ? x : ~x;
  endfunction
endpackage

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output lcr_t       lcr_o
);
  lcr_t lcr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lcr_q <= '0;
    else if (we_i) lcr_q <= lcr_t'(wdata_i);
  end

  assign lcr_o = lcr_q;
endmodule

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (load_i) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  // R9
  load_keeps_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> full_o);
  // R8
  take_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !load_i) |=> !full_o);
endmodule

// File: rtl/async_tx_frame.sv
module async_tx_frame
  import async_tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       full_i,
  input  logic [7:0] data_i,
  input  logic [1:0] len_i,
  input  logic       stop2_i,
  input  logic       par_en_i,
  input  logic       even_i,
  input  logic       stick_i,
  output logic       take_o,
  output logic       busy_o,
  output logic       edge_o,
  output logic       line_o
);
  localparam int unsigned CNT_W = $clog2(2 * TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2 * TICKS_PER_BIT - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] stop_lim_q;
  logic [CNT_W-1:0] lim;
  logic [2:0]       idx_q;
  logic [2:0]       last_q;
  logic [7:0]       sh_q;
  logic             par_q;
  logic             pen_q;
  logic             busy;
  logic             start;
  logic             adv;

  assign busy  = (phase_q != PH_IDLE);
  assign start = !busy && full_i;
  assign lim   = (phase_q == PH_STOP) ? stop_lim_q : LIM_ONE;
  assign adv   = busy && tick_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      stop_lim_q <= LIM_ONE;
      idx_q      <= '0;
      last_q     <= '0;
      sh_q       <= '0;
      par_q      <= 1'b0;
      pen_q      <= 1'b0;
    end else if (start) begin
      phase_q    <= PH_START;
      cnt_q      <= '0;
      idx_q      <= '0;
      last_q     <= {1'b1, len_i};
      sh_q       <= data_i;
      pen_q      <= par_en_i;
      par_q      <= parity_bit(data_i, len_i, even_i, stick_i);
      stop_lim_q <= !stop2_i ? LIM_ONE : (len_i == 2'b00) ? LIM_HALF : LIM_TWO;
    end else if (busy && tick_i) begin
      if (!adv) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        unique case (phase_q)
          PH_START: phase_q <= PH_DATA;
          PH_DATA: begin
            if (idx_q == last_q) begin
              phase_q <= pen_q ? PH_PARITY : PH_STOP;
            end else begin
              idx_q <= idx_q + 1'b1;
              sh_q  <= {1'b0, sh_q[7:1]};
            end
          end
          PH_PARITY: phase_q <= PH_STOP;
          default:   phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_START:  line_o = 1'b0;
      PH_DATA:   line_o = sh_q[0];
      PH_PARITY: line_o = par_q;
      default:   line_o = 1'b1;
    endcase
  end

  assign take_o = start;
  assign busy_o = busy;
  assign edge_o = adv;

  // R8
  start_needs_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(full_i));
  // R12
  hold_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> ($stable(phase_q) && $stable(cnt_q)));
  // R2
  data_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DATA) |-> (idx_q <= last_q));
  // R12
  idle_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !full_i) |=> !busy_o);
endmodule

// File: rtl/async_tx_line.sv
module async_tx_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic brk_i,
  input  logic busy_i,
  input  logic edge_i,
  input  logic frame_line_i,
  output logic txd_o
);
  logic brk_hold_q;

  // break stays in force until the current bit ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brk_hold_q <= 1'b0;
    else         brk_hold_q <= brk_i | (brk_hold_q & busy_i & ~edge_i);
  end

  assign txd_o = ~(brk_i | brk_hold_q) & frame_line_i;

  // R7
  hold_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!brk_i && !busy_i) |=> !brk_hold_q);
endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lcr_we_i,
  input  logic [7:0] lcr_wdata_i,
  output logic [7:0] lcr_rdata_o,
  input  logic       thr_load_i,
  input  logic [7:0] thr_data_i,
  input  logic       tick_i,
  output logic       thr_empty_o,
  output logic       tx_busy_o,
  output logic       txd_o
);
  lcr_t       lcr;
  logic       full;
  logic [7:0] hold_data;
  logic       take;
  logic       busy;
  logic       bit_edge;
  logic       frame_line;

  async_tx_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (lcr_we_i),
    .wdata_i (lcr_wdata_i),
    .lcr_o   (lcr)
  );

  async_tx_hold #(.DATA_W(8)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (thr_load_i),
    .data_i (thr_data_i),
    .take_i (take),
    .full_o (full),
    .data_o (hold_data)
  );

  async_tx_frame #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .full_i   (full),
    .data_i   (hold_data),
    .len_i    (lcr.len),
    .stop2_i  (lcr.stop2),
    .par_en_i (lcr.par_en),
    .even_i   (lcr.even),
    .stick_i  (lcr.stick),
    .take_o   (take),
    .busy_o   (busy),
    .edge_o   (bit_edge),
    .line_o   (frame_line)
  );

  async_tx_line u_line (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .brk_i        (lcr.brk),
    .busy_i       (busy),
    .edge_i       (bit_edge),
    .frame_line_i (frame_line),
    .txd_o        (txd_o)
  );

  assign lcr_rdata_o = lcr;
  assign thr_empty_o = !full;
  assign tx_busy_o   = busy;

  // R7
  break_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcr_rdata_o[6] |-> !txd_o);
  // R8
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_busy_o && !lcr_rdata_o[6] && $past(!lcr_rdata_o[6])) |-> txd_o);
endmodule

// File: tb/sim_async_tx.sv
`timescale 1ns/1ps
module sim_async_tx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lcr_we_i = 1'b0;
  logic [7:0] lcr_wdata_i = '0;
  logic [7:0] lcr_rdata_o;
  logic       thr_load_i = 1'b0;
  logic [7:0] thr_data_i = '0;
  logic       tick_i = 1'b0;
  logic       thr_empty_o;
  logic       tx_busy_o;
  logic       txd_o;

  async_tx u0 (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit tick_en = 1'b1;
  int tick_div = 0;

  // reference model state
  logic [7:0] m_lcr, m_flcr, m_data;
  bit m_full, m_busy, m_brk;
  int seg_lvl[$];
  int seg_dur[$];
  string seg_tag[$];

  task automatic check(input int act, input int exp, input string req, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit par_of(logic [7:0] d, logic [7:0] l);
    int n = 5 + int'(l[1:0]);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += int'(d[i]);
    if (l[5]) return !l[4];
    if (l[4]) return (ones % 2) == 1;
    return (ones % 2) == 0;
  endfunction

  task automatic build(logic [7:0] d, logic [7:0] l);
    int n = 5 + int'(l[1:0]);
    seg_lvl.delete(); seg_dur.delete(); seg_tag.delete();
    seg_lvl.push_back(0); seg_dur.push_back(16); seg_tag.push_back("R2");
    for (int i = 0; i < n; i++) begin
      seg_lvl.push_back(int'(d[i])); seg_dur.push_back(16); seg_tag.push_back("R2");
    end
    if (l[3]) begin
      seg_lvl.push_back(int'(par_of(d, l))); seg_dur.push_back(16);
      seg_tag.push_back(l[5] ? "R6" : "R5");
    end
    seg_lvl.push_back(1);
    seg_dur.push_back(!l[2] ? 16 : (l[1:0] == 2'b00) ? 24 : 32);
    seg_tag.push_back(l[3] ? "R3" : "R4");
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lcr = '0; m_flcr = '0; m_data = '0;
      m_full = 0; m_busy = 0; m_brk = 0;
      seg_lvl.delete(); seg_dur.delete(); seg_tag.delete();
    end else begin
      bit bnd, take;
      bnd = m_busy && tick_i && (seg_dur[0] == 1);
      take = 0;
      m_brk = m_lcr[6] || (m_brk && m_busy && !bnd);
      if (m_busy) begin
        if (tick_i) begin
          seg_dur[0] = seg_dur[0] - 1;
          if (seg_dur[0] == 0) begin
            void'(seg_lvl.pop_front()); void'(seg_dur.pop_front()); void'(seg_tag.pop_front());
            if (seg_lvl.size() == 0) m_busy = 0;
          end
        end
      end else if (m_full) begin
        build(m_data, m_lcr);
        m_flcr = m_lcr;
        m_busy = 1;
        take = 1;
      end
      if (lcr_we_i) m_lcr = lcr_wdata_i;
      if (thr_load_i) begin m_full = 1; m_data = thr_data_i; end
      else if (take) m_full = 0;
    end
  end

  // tick generator and per-cycle comparison
  always @(negedge clk_i) begin
    cyc++;
    tick_div = (tick_div == 2) ? 0 : tick_div + 1;
    tick_i <= tick_en && (tick_div == 0);
    if (rst_ni && !done) begin
      int exp_txd;
      string tg;
      if (m_lcr[6] || m_brk) begin exp_txd = 0; tg = "R7"; end
      else if (m_busy) begin
        exp_txd = seg_lvl[0];
        tg = (m_lcr[5:0] != m_flcr[5:0]) ? "R11" : seg_tag[0];
      end else begin exp_txd = 1; tg = "R8"; end
      check(int'(txd_o), exp_txd, tg, "txd_o");
      check(int'(thr_empty_o), int'(!m_full), "R8", "thr_empty_o");
      check(int'(tx_busy_o), int'(m_busy), "R8", "tx_busy_o");
      check(int'(lcr_rdata_o), int'(m_lcr), "R10", "lcr_rdata_o");
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_lcr(logic [7:0] v);
    @(negedge clk_i); lcr_we_i = 1; lcr_wdata_i = v;
    @(negedge clk_i); lcr_we_i = 0;
  endtask

  task automatic load(logic [7:0] v);
    @(negedge clk_i); thr_load_i = 1; thr_data_i = v;
    @(negedge clk_i); thr_load_i = 0;
  endtask

  task automatic wait_idle();
    while (m_busy || m_full) @(negedge clk_i);
    step(3);
  endtask

  task automatic send(logic [7:0] l, logic [7:0] d);
    wr_lcr(l); load(d); wait_idle();
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    while (cyc < 150000) @(negedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
    finish_run();
  end

  initial begin
    step(3);
    // R1 reset state
    check(int'(txd_o), 1, "R1", "txd_o at reset");
    check(int'(thr_empty_o), 1, "R1", "thr_empty_o at reset");
    check(int'(tx_busy_o), 0, "R1", "tx_busy_o at reset");
    check(int'(lcr_rdata_o), 0, "R1", "lcr_rdata_o at reset");
    rst_ni = 1;
    step(20);  // R12 ticks while idle
    check(int'(txd_o), 1, "R12", "idle line with ticks");

    send(8'h03, 8'hA5);  // 8N1
    send(8'h04, 8'h1B);  // 5 bits, 1.5 stop
    send(8'h1E, 8'h35);  // 7 even, 2 stop
    send(8'h09, 8'h2C);  // 6 odd
    send(8'h1D, 8'h13);  // 6 even, 2 stop
    send(8'h2B, 8'h00);  // stick 1
    send(8'h3B, 8'hFF);  // stick 0
    send(8'h0C, 8'h0E);  // 5 odd, 1.5 stop

    // R10 bit 7 stored, framing unchanged
    wr_lcr(8'h83);
    check(int'(lcr_rdata_o), 8'h83, "R10", "bit7 readback");
    load(8'h5A); wait_idle();

    // R8 second word loaded mid-frame waits
    wr_lcr(8'h03);
    load(8'h81); step(100); load(8'h7E);
    check(int'(thr_empty_o), 0, "R8", "word waits while busy");
    wait_idle();

    // R9 load coinciding with take
    @(negedge clk_i); thr_load_i = 1; thr_data_i = 8'hC3;
    @(negedge clk_i); thr_data_i = 8'h3C;
    @(negedge clk_i); thr_load_i = 0;
    check(int'(thr_empty_o), 0, "R9", "empty after overlapping load");
    check(int'(tx_busy_o), 1, "R9", "busy after overlapping load");
    wait_idle();

    // R7 break during frame, cleared mid-bit
    wr_lcr(8'h43);
    check(int'(txd_o), 0, "R7", "break forces low");
    load(8'hF0); step(130);
    wr_lcr(8'h03);
    step(50);
    wait_idle();
    wr_lcr(8'h43); step(10); wr_lcr(8'h03); step(5);
    check(int'(txd_o), 1, "R7", "idle after break");

    // R11 format change mid-frame
    wr_lcr(8'h03); load(8'h96); step(60);
    wr_lcr(8'h1C); wait_idle();

    // R12 no ticks: frame frozen
    tick_en = 0;
    wr_lcr(8'h03); load(8'h55); step(60);
    check(int'(txd_o), 0, "R12", "start bit held without ticks");
    check(int'(tx_busy_o), 1, "R12", "busy held without ticks");
    tick_en = 1;
    wait_idle();

    finish_run();
  end
endmodule